// File: doc/BRIEF.md
# Keypad Scancode Decoder

This block sits behind a keyboard receiver in a calculator input path. It takes a stream of Set 2 scancode bytes, one byte per single-cycle strobe. For each key press it produces at most one 8-bit character code, marked by a valid pulse one clock wide. Key releases are filtered out, and prefix bytes are absorbed.

Only a small set of keys is accepted: the ten keypad digits, the keypad operators, space, enter and backspace. The keypad divide key shares its base code with a key on the main block. It is therefore accepted only when it arrives behind the extended prefix. Every other code is dropped without any output.

Top module: `kpd_scan_decoder`

## Requirements
- R1: While rst_ni is low, valid_o is low. Reset also clears any pending release or extended state, so the first byte after reset is decoded as if no prefix had come before it.
- R2: Keypad digit codes 0x70, 0x69, 0x72, 0x7A, 0x6B, 0x73, 0x74, 0x6C, 0x75 and 0x7D map to the digits 0 to 9 in that order, emitted as the codes 0x30 to 0x39.
- R3: Unprefixed 0x79 emits 0x2B, 0x7B emits 0x2D, 0x7C emits 0x2A, 0x29 emits 0x20, 0x5A emits 0x1C and 0x66 emits 0x0E.
- R4: A byte strobed at clock edge k that is accepted gives valid_o high with char_o holding the code from edge k until edge k+1. The pulse is exactly one cycle wide.
- R5: After 0xF0, the next non-prefix byte produces no output, whatever its value.
- R6: The release state clears once that next non-prefix byte has been consumed. A valid key strobed after it is emitted normally.
- R7: The bytes 0xF0 and 0xE0 never produce an output themselves.
- R8: The sequence 0xE0 followed by 0x4A emits 0x2F. A 0x4A with no extended prefix produces no output.
- R9: The extended state clears after any non-prefix byte. A later unprefixed 0x4A is dropped.
- R10: Behind 0xE0 only 0x4A and 0x5A (enter, emitted as 0x1C) are accepted. Any other extended code, including the keypad digit codes, is dropped.
- R11: Any byte outside the accepted set produces no output. Every code that appears on char_o while valid_o is high belongs to the 17 characters listed in R2, R3 and R8.
- R12: No output is produced in a cycle that follows one without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Scancode byte |
| strobe_i | input | 1 | One-cycle marker that data_i holds a new byte |
| char_o | output | 8 | Decoded character code, valid while valid_o is high |
| valid_o | output | 1 | One-cycle pulse marking a new character |

## Verification
The stimulus goes after the prefix corner cases:
- A release followed by a valid key. A design that failed to drop it would emit a character on key-up.
- A bare 0x4A. A design that ignored the prefix would emit a divide for the main-block key.
- An extended prefix followed by a keypad digit code, which must stay silent.
- A prefix left pending across a reset. A design that failed to clear it would swallow the first key after reset.
- Repeated prefixes and random bytes between valid keys. These show whether the prefix state lingers too long or clears too early.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  localparam int unsigned CODE_W = 8;
  typedef logic [CODE_W-1:0] code_t;

  localparam code_t BREAK_CODE = 8'hF0;
  localparam code_t EXT_CODE   = 8'hE0;

  typedef struct packed {
    logic  hit;
    code_t chr;
  } map_t;

  function automatic map_t kpd_map(code_t sc, logic ext, logic ext_enter_en);
    map_t m;
    m.hit = 1'b1;
    m.chr = '0;
    if (ext) begin
      if (sc == 8'h4A) m.chr = 8'h2F;
      else if (sc == 8'h5A && ext_enter_en) m.chr = 8'h1C;
      else m.hit = 1'b0;
    end else begin
      case (sc)
        8'h70: m.chr = 8'h30;
        8'h69: m.chr = 8'h31;
        8'h72: m.chr = 8'h32;
        8'h7A: m.chr = 8'h33;
        8'h6B: m.chr = 8'h34;
        8'h73: m.chr = 8'h35;
        8'h74: m.chr = 8'h36;
        8'h6C: m.chr = 8'h37;
        8'h75: m.chr = 8'h38;
        8'h7D: m.chr = 8'h39;
        8'h79: m.chr = 8'h2B;
        8'h7B: m.chr = 8'h2D;
        8'h7C: m.chr = 8'h2A;
        8'h29: m.chr = 8'h20;
        8'h5A: m.chr = 8'h1C;
        8'h66: m.chr = 8'h0E;
        default: m.hit = 1'b0;
      endcase
    end
    return m;
  endfunction

  function automatic logic is_key_char(code_t c);
    return (c >= 8'h30 && c <= 8'h39) || c == 8'h2B || c == 8'h2D ||
           c == 8'h2A || c == 8'h2F || c == 8'h20 || c == 8'h1C || c == 8'h0E;
  endfunction
endpackage

// File: rtl/kpd_prefix_track.sv
module kpd_prefix_track
  import kpd_pkg::*;
#(
  parameter code_t BRK = BREAK_CODE,
  parameter code_t EXT = EXT_CODE
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  strobe_i,
  input  code_t data_i,
  output logic  rel_o,
  output logic  ext_o,
  output logic  cand_o
);
  logic rel_q, ext_q, is_brk, is_ext;

  assign is_brk = (data_i == BRK);
  assign is_ext = (data_i == EXT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_q <= 1'b0;
      ext_q <= 1'b0;
    end else if (strobe_i) begin
      if (is_brk) rel_q <= 1'b1;
      else if (is_ext) ext_q <= 1'b1;
      else begin
        rel_q <= 1'b0;
        ext_q <= 1'b0;
      end
    end
  end

  // a plain byte that is not the tail of a release sequence
  assign cand_o = strobe_i && !is_brk && !is_ext && !rel_q;
  assign rel_o  = rel_q;
  assign ext_o  = ext_q;
endmodule

// File: rtl/kpd_keymap.sv
module kpd_keymap
  import kpd_pkg::*;
#(
  parameter bit EXT_ENTER_EN = 1'b1
) (
  input  code_t sc_i,
  input  logic  ext_i,
  output logic  hit_o,
  output code_t chr_o
);
  map_t m;
  generate
    if (EXT_ENTER_EN) begin : g_ext_enter
      assign m = kpd_map(sc_i, ext_i, 1'b1);
    end else begin : g_no_ext_enter
      assign m = kpd_map(sc_i, ext_i, 1'b0);
    end
  endgenerate
  assign hit_o = m.hit;
  assign chr_o = m.chr;
endmodule

// File: rtl/kpd_out_reg.sv
module kpd_out_reg
  import kpd_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  fire_i,
  input  code_t chr_i,
  output logic  valid_o,
  output code_t char_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      char_o  <= '0;
    end else begin
      valid_o <= fire_i;
      if (fire_i) char_o <= chr_i;
    end
  end
endmodule

// File: rtl/kpd_scan_decoder.sv
module kpd_scan_decoder
  import kpd_pkg::*;
#(
  parameter code_t BRK          = BREAK_CODE,
  parameter code_t EXT          = EXT_CODE,
  parameter bit    EXT_ENTER_EN = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] data_i,
  input  logic       strobe_i,
  output logic [7:0] char_o,
  output logic       valid_o
);
  logic  rel_w, ext_w, cand_w, hit_w;
  code_t chr_w;

  kpd_prefix_track #(.BRK(BRK), .EXT(EXT)) u_pfx (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i), .data_i(data_i),
    .rel_o(rel_w), .ext_o(ext_w), .cand_o(cand_w)
  );

  kpd_keymap #(.EXT_ENTER_EN(EXT_ENTER_EN)) u_map (
    .sc_i(data_i), .ext_i(ext_w), .hit_o(hit_w), .chr_o(chr_w)
  );

  kpd_out_reg u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(cand_w && hit_w), .chr_i(chr_w),
    .valid_o(valid_o), .char_o(char_o)
  );
endmodule

// File: rtl/kpd_scan_decoder_chk.sv
module kpd_scan_decoder_chk
  import kpd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] data_i,
  input logic       strobe_i,
  input logic [7:0] char_o,
  input logic       valid_o,
  input logic       rel_q,
  input logic       ext_q
);
  logic is_pfx;
  assign is_pfx = (data_i == BREAK_CODE) || (data_i == EXT_CODE);

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !valid_o);

  assert_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_release_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && rel_q && !is_pfx |=> !valid_o);

  assert_prefix_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && is_pfx |=> !valid_o);

  assert_bare_div_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && !ext_q && data_i == 8'h4A |=> !valid_o);

  assert_ext_filter_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && ext_q && !is_pfx && data_i != 8'h4A && data_i != 8'h5A |=> !valid_o);

  assert_legal_char_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> is_key_char(char_o));

  assert_no_strobe_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> !valid_o);
endmodule

bind kpd_scan_decoder kpd_scan_decoder_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .strobe_i(strobe_i),
  .char_o(char_o), .valid_o(valid_o), .rel_q(rel_w), .ext_q(ext_w)
);

// File: tb/tb_kpd_scan_decoder.sv
module tb_kpd_scan_decoder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = '0;
  logic       strobe_i = 1'b0;
  logic [7:0] char_o;
  logic       valid_o;

  int total = 0;
  int bad = 0;
  logic m_rel = 1'b0;
  logic m_ext = 1'b0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  kpd_scan_decoder dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .strobe_i(strobe_i),
    .char_o(char_o), .valid_o(valid_o)
  );

  function automatic logic [7:0] exp_chr(logic [7:0] b, logic ext, output bit hit);
    hit = 1'b1;
    if (ext) begin
      if (b == 8'h4A) return 8'h2F;
      if (b == 8'h5A) return 8'h1C;
      hit = 1'b0;
      return 8'h00;
    end
    case (b)
      8'h70: return 8'h30; 8'h69: return 8'h31; 8'h72: return 8'h32;
      8'h7A: return 8'h33; 8'h6B: return 8'h34; 8'h73: return 8'h35;
      8'h74: return 8'h36; 8'h6C: return 8'h37; 8'h75: return 8'h38;
      8'h7D: return 8'h39; 8'h79: return 8'h2B; 8'h7B: return 8'h2D;
      8'h7C: return 8'h2A; 8'h29: return 8'h20; 8'h5A: return 8'h1C;
      8'h66: return 8'h0E;
      default: begin hit = 1'b0; return 8'h00; end
    endcase
  endfunction

  function automatic logic [7:0] key_at(int i);
    logic [7:0] k [17] = '{8'h70, 8'h69, 8'h72, 8'h7A, 8'h6B, 8'h73, 8'h74, 8'h6C,
                           8'h75, 8'h7D, 8'h79, 8'h7B, 8'h7C, 8'h29, 8'h5A, 8'h66, 8'h4A};
    return k[i % 17];
  endfunction

  function automatic string tag_of(logic [7:0] b, logic rel, logic ext, bit hit);
    if (b == 8'hF0 || b == 8'hE0) return "R7";
    if (rel) return "R5";
    if (b == 8'h4A) return "R8";
    if (ext) return hit ? "R8" : "R10";
    if (!hit) return "R11";
    if (b >= 8'h69 && b <= 8'h7D && b != 8'h79 && b != 8'h7B && b != 8'h7C) return "R2";
    return "R3";
  endfunction

  task automatic check(string tag, logic [7:0] av, logic [7:0] ev, logic ac, logic ec);
    total++;
    if (ac !== ec || (ec && av !== ev)) begin
      bad++;
      $display("FAIL %s: valid=%0b char=%02h expected valid=%0b char=%02h", tag, ac, av, ec, ev);
    end
  endtask

  task automatic send(logic [7:0] b);
    bit hit;
    logic [7:0] e;
    string tag;
    e = exp_chr(b, m_ext, hit);
    if (m_rel || b == 8'hF0 || b == 8'hE0) hit = 1'b0;
    tag = tag_of(b, m_rel, m_ext, hit);
    @(negedge clk_i);
    data_i = b;
    strobe_i = 1'b1;
    @(negedge clk_i);
    strobe_i = 1'b0;
    check(tag, char_o, e, valid_o, hit);      // R4 timing: one cycle after strobe
    if (b == 8'hF0) m_rel = 1'b1;
    else if (b == 8'hE0) m_ext = 1'b1;
    else begin m_rel = 1'b0; m_ext = 1'b0; end
    @(negedge clk_i);
    check("R4", char_o, 8'h00, valid_o, 1'b0); // pulse width one cycle
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    strobe_i = 1'b0;
    #1;
    check("R1", char_o, 8'h00, valid_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_rel = 1'b0;
    m_ext = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: valid=x char=xx expected valid=x char=xx");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5521));
    #1;
    check("R1", char_o, 8'h00, valid_o, 1'b0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R2 / R3: every plain key
    for (int i = 0; i < 16; i++) send(key_at(i));
    // R8: bare divide dropped, extended divide accepted
    send(8'h4A);
    send(8'hE0); send(8'h4A);
    // R9: extended cleared after divide
    send(8'h4A);
    // R10: extended digit dropped, extended enter accepted
    send(8'hE0); send(8'h70);
    send(8'hE0); send(8'h5A);
    // R5 / R6: release then key dropped, next key accepted
    send(8'hF0); send(8'h70); send(8'h70);
    // release of extended divide
    send(8'hE0); send(8'hF0); send(8'h4A); send(8'h79);
    // R11: unlisted bytes
    send(8'h41); send(8'h00); send(8'hFF);
    // R12: idle gap, no output
    repeat (4) begin
      @(negedge clk_i);
      check("R12", char_o, 8'h00, valid_o, 1'b0);
    end
    // R1: pending prefixes cleared by reset
    send(8'hF0); do_reset(); send(8'h70);
    send(8'hE0); do_reset(); send(8'h4A);
    // random mix
    for (int n = 0; n < 800; n++) begin
      int r;
      r = $urandom % 10;
      case (r)
        0, 1, 2, 3, 4: send(key_at($urandom % 17));
        5: send(8'hF0);
        6: send(8'hE0);
        7: send(8'($urandom));
        8: send(8'h4A);
        default: send(8'h5A);
      endcase
      if ((n % 97) == 96) do_reset();
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule